// File: doc/BRIEF.md
# Selectable Byte Sequence Generator

This block produces a stream of test bytes for bus stress runs. A start strobe launches one transfer. The strobe captures three inputs: the sequence to use, the number of bytes and a starting value. The block then offers the bytes one at a time on a valid/ready handshake, so that a transmit queue can take them at its own pace. The same block can also serve as the expected-value source when data read back from a device is compared.

Three sequences come from one engine. The first is a plain count up from the starting value. The second is the Gray-coded form of that count. The third is the Fibonacci series reduced modulo 256. The transfer length can be anything from 0 to 240 bytes, and every transfer may use a different sequence and length. The surrounding control logic chooses these settings, randomly or otherwise. When the last byte has been taken, a one-cycle completion pulse follows.

Top module: `stress_pattern_gen`

## Requirements
- R1: During and directly after reset, `valid_o` and `done_o` are low.
- R2: With `sel_i` = 0, byte k of a transfer (k counted from 0) equals (seed + k) mod 256.
- R3: With `sel_i` = 1, byte k equals c ^ (c >> 1), where c = (seed + k) mod 256; two bytes in a row therefore differ in exactly one bit.
- R4: With `sel_i` = 2, the bytes are 0, 1, 1, 2, 3, 5, 8, …, each one the sum modulo 256 of the two before it, and the seed has no effect.
- R5: `sel_i` = 3 behaves exactly as `sel_i` = 0.
- R6: A count N from 1 to 240 produces exactly N accepted bytes. Any count above 240 produces exactly 240.
- R7: A count of 0 raises `done_o` in the cycle after the start is sampled and produces no cycle with `valid_o` high.
- R8: `done_o` is high for exactly one cycle. That cycle directly follows the clock edge on which the last byte was accepted, and `valid_o` is low in it.
- R9: While `valid_o` is high and `ready_i` is low, `valid_o` and `data_o` hold their values. The sequence moves on only on an edge where both are high.
- R10: A start strobe given while a transfer is in progress is ignored, and the running transfer continues unchanged.
- R11: `sel_i`, `count_i` and `seed_i` are sampled only when a start is accepted. Changing them during a transfer has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches a transfer when the block is idle |
| sel_i | input | 2 | Sequence: 0 count, 1 Gray, 2 Fibonacci, 3 count |
| count_i | input | 8 | Number of bytes in the transfer (values above 240 are limited to 240) |
| seed_i | input | 8 | Starting value for the count and Gray sequences |
| ready_i | input | 1 | The consumer can take a byte this cycle |
| data_o | output | 8 | Current byte |
| valid_o | output | 1 | `data_o` holds a byte that has not yet been accepted |
| done_o | output | 1 | One-cycle pulse when a transfer has finished |

## Verification
The embedded properties assume that `ready_i` is an ordinary level from the consumer. They also assume that settings presented with a start strobe are held at least for the edge on which the strobe is sampled. The stepping properties assume that a start never lands on the same edge as an accepted byte. That holds because a start only takes effect while `valid_o` is low. Bench stimulus changes every input on the falling clock edge. It stalls `ready_i` in a fixed rhythm, and it fires a conflicting start with altered settings in the middle of one transfer. This exercises the hold and ignore rules without breaking what the properties assume.

// File: rtl/spg_pkg.sv
package spg_pkg;

   typedef enum logic [1:0] {
      PAT_COUNT = 2'd0,
      PAT_GRAY  = 2'd1,
      PAT_FIB   = 2'd2,
      PAT_ALIAS = 2'd3
   } pat_e;

endpackage

// File: rtl/spg_beat_ctrl.sv
module spg_beat_ctrl #(
   parameter int CW        = 8,
   parameter int MAX_BEATS = 240
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [CW-1:0] count_i,
   input  logic          ready_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          load_o,
   output logic          fire_o
);

   localparam logic [CW-1:0] LIMIT = CW'(MAX_BEATS);
   localparam logic [CW-1:0] ONE   = CW'(1);

   if (CW < 2) begin : g_cw_bad
      $error("spg_beat_ctrl: CW must be at least 2");
   end
   if (MAX_BEATS < 1 || MAX_BEATS >= (1 << CW)) begin : g_max_bad
      $error("spg_beat_ctrl: MAX_BEATS must fit in CW bits");
   end

   logic          busy_q;
   logic          done_q;
   logic [CW-1:0] left_q;
   logic [CW-1:0] clamped;

   assign clamped = (count_i > LIMIT) ? LIMIT : count_i;
   assign load_o  = start_i && !busy_q;
   assign fire_o  = busy_q && ready_i;
   assign busy_o  = busy_q;
   assign done_o  = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         left_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (load_o) begin
            left_q <= clamped;
            busy_q <= (clamped != '0);
            done_q <= (clamped == '0);
         end else if (fire_o) begin
            left_q <= left_q - ONE;
            if (left_q == ONE) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   // R6
   left_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      left_q <= LIMIT);

   // R6
   busy_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (left_q != '0));

   // R10
   busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start_i && !ready_i) |=> (busy_q && $stable(left_q)));

endmodule

// File: rtl/spg_seq_core.sv
module spg_seq_core
   import spg_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          adv_i,
   input  pat_e          sel_i,
   input  logic [DW-1:0] seed_i,
   output logic [DW-1:0] data_o
);

   localparam logic [DW-1:0] ONE = DW'(1);

   if (DW < 2) begin : g_dw_bad
      $error("spg_seq_core: DW must be at least 2");
   end

   pat_e          sel_q;
   logic [DW-1:0] cnt_q;
   logic [DW-1:0] fa_q;
   logic [DW-1:0] fb_q;
   logic [DW-1:0] gray;

   for (genvar i = 0; i < DW - 1; i++) begin : g_gray
      assign gray[i] = cnt_q[i] ^ cnt_q[i+1];
   end
   assign gray[DW-1] = cnt_q[DW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= PAT_COUNT;
         cnt_q <= '0;
         fa_q  <= '0;
         fb_q  <= ONE;
      end else if (load_i) begin
         sel_q <= sel_i;
         cnt_q <= seed_i;
         fa_q  <= '0;
         fb_q  <= ONE;
      end else if (adv_i) begin
         cnt_q <= cnt_q + ONE;
         fa_q  <= fb_q;
         fb_q  <= fa_q + fb_q;
      end
   end

   always_comb begin
      unique case (sel_q)
         PAT_GRAY: data_o = gray;
         PAT_FIB:  data_o = fa_q;
         default:  data_o = cnt_q;
      endcase
   end

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !load_i && (sel_q == PAT_COUNT || sel_q == PAT_ALIAS))
         |=> (data_o == $past(data_o) + ONE));

   // R3
   gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !load_i && sel_q == PAT_GRAY)
         |=> ($countones(data_o ^ $past(data_o)) == 1));

   // R4
   fib_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && sel_i == PAT_FIB) |=> (data_o == '0));

endmodule

// File: rtl/stress_pattern_gen.sv
module stress_pattern_gen
   import spg_pkg::*;
#(
   parameter int DW        = 8,
   parameter int CW        = 8,
   parameter int MAX_BEATS = 240
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [1:0]    sel_i,
   input  logic [CW-1:0] count_i,
   input  logic [DW-1:0] seed_i,
   input  logic          ready_i,
   output logic [DW-1:0] data_o,
   output logic          valid_o,
   output logic          done_o
);

   logic busy;
   logic load;
   logic fire;

   spg_beat_ctrl #(.CW(CW), .MAX_BEATS(MAX_BEATS)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .count_i (count_i),
      .ready_i (ready_i),
      .busy_o  (busy),
      .done_o  (done_o),
      .load_o  (load),
      .fire_o  (fire)
   );

   spg_seq_core #(.DW(DW)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .adv_i  (fire),
      .sel_i  (pat_e'(sel_i)),
      .seed_i (seed_i),
      .data_o (data_o)
   );

   assign valid_o = busy;

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

   // R8
   done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && valid_o));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7
   zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !valid_o && count_i == '0) |=> (done_o && !valid_o));

   // R6
   start_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !valid_o && count_i != '0) |=> valid_o);

endmodule

// File: tb/stress_pattern_gen_bench.sv
module stress_pattern_gen_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [1:0] sel_i = 2'd0;
   logic [7:0] count_i = 8'd0;
   logic [7:0] seed_i = 8'd0;
   logic       ready_i = 1'b0;
   logic [7:0] data_o;
   logic       valid_o;
   logic       done_o;

   int checks = 0;
   int fails = 0;

   always #10 clk = ~clk;

   stress_pattern_gen u_stress_pattern_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .sel_i   (sel_i),
      .count_i (count_i),
      .seed_i  (seed_i),
      .ready_i (ready_i),
      .data_o  (data_o),
      .valid_o (valid_o),
      .done_o  (done_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   function automatic logic [7:0] exp_byte(input logic [1:0] s, input logic [7:0] sd, input int k);
      logic [7:0] a, b, t, c;
      c = sd + k[7:0];
      case (s)
         2'd1: return c ^ (c >> 1);
         2'd2: begin
            a = 8'd0;
            b = 8'd1;
            for (int i = 0; i < k; i++) begin
               t = a + b;
               a = b;
               b = t;
            end
            return a;
         end
         default: return c;
      endcase
   endfunction

   task automatic do_xfer(input logic [1:0] sel, input int cnt, input logic [7:0] seed,
                          input bit stall, input bit poke, input string req);
      int k = 0;
      int exp_n = (cnt > 240) ? 240 : cnt;
      int last_fire = -1;
      int done_cyc = -1;
      bit hold_v = 0;
      logic [7:0] hold_d = 8'd0;
      logic [7:0] e;
      @(negedge clk);
      start_i = 1'b1;
      sel_i   = sel;
      count_i = cnt[7:0];
      seed_i  = seed;
      ready_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      for (int cyc = 0; cyc < 3000; cyc++) begin
         if (poke) begin
            if (cyc == 2) begin
               start_i = 1'b1;
               sel_i   = 2'd2;
               count_i = 8'd3;
               seed_i  = ~seed;
            end else if (cyc == 3) begin
               start_i = 1'b0;
            end
         end
         if (hold_v) begin
            check(valid_o && data_o == hold_d, "R9", data_o, hold_d);
            hold_v = 0;
         end
         if (done_o) begin
            check(!valid_o, "R8", valid_o, 0);
            done_cyc = cyc;
            break;
         end
         ready_i = stall ? (cyc % 3 != 1) : 1'b1;
         if (valid_o) begin
            if (ready_i) begin
               e = exp_byte(sel, seed, k);
               check(data_o == e, req, data_o, e);
               k++;
               last_fire = cyc;
            end else begin
               hold_v = 1;
               hold_d = data_o;
            end
         end
         @(negedge clk);
      end
      ready_i = 1'b0;
      if (cnt == 0)
         check(done_cyc == 0, "R7", done_cyc, 0);
      else
         check(done_cyc == last_fire + 1, "R8", done_cyc, last_fire + 1);
      check(k == exp_n, (cnt == 0) ? "R7" : (poke ? "R10" : "R6"), k, exp_n);
      @(negedge clk);
      check(!done_o && !valid_o, "R8", done_o, 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(!valid_o && !done_o, "R1", {valid_o, done_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!valid_o && !done_o, "R1", {valid_o, done_o}, 0);
   endtask

   task automatic t_count();
      do_xfer(2'd0, 8, 8'h00, 0, 0, "R2");
      do_xfer(2'd0, 16, 8'hF8, 0, 0, "R2");
   endtask

   task automatic t_gray();
      do_xfer(2'd1, 32, 8'h7C, 0, 0, "R3");
      do_xfer(2'd1, 64, 8'h00, 0, 0, "R3");
   endtask

   task automatic t_fib();
      do_xfer(2'd2, 16, 8'h00, 0, 0, "R4");
      do_xfer(2'd2, 20, 8'hAA, 0, 0, "R4");
   endtask

   task automatic t_alias();
      do_xfer(2'd3, 8, 8'h33, 0, 0, "R5");
   endtask

   task automatic t_lengths();
      do_xfer(2'd0, 1, 8'h10, 0, 0, "R6");
      do_xfer(2'd2, 240, 8'h00, 0, 0, "R6");
      do_xfer(2'd0, 255, 8'h05, 0, 0, "R6");
   endtask

   task automatic t_zero();
      do_xfer(2'd1, 0, 8'h44, 0, 0, "R7");
   endtask

   task automatic t_stall();
      do_xfer(2'd1, 12, 8'hFE, 1, 0, "R9");
   endtask

   task automatic t_busy_start();
      // R10 and R11: start strobe and new settings arrive mid-transfer
      do_xfer(2'd0, 6, 8'h20, 1, 1, "R11");
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", 150000, 0);
      report();
   end

   initial begin
      t_reset();
      t_count();
      t_gray();
      t_fib();
      t_alias();
      t_lengths();
      t_zero();
      t_stall();
      t_busy_start();
      report();
   end

endmodule